// File: doc/BRIEF.md
# SDRAM Command Front End with Bank State Tracking

This block is the device-side command front end of a four-bank, 16-bit synchronous DRAM. It samples the chip-select, row strobe, column strobe, write-enable, clock-enable, bank-select, address and byte-mask pins on every rising clock edge. From them it produces one registered internal strobe per accepted command (activate, read, write, precharge, refresh, mode load). It keeps an open/closed flag and the latched row for every bank. It follows the length of each burst, so that a bank marked for auto-precharge is closed when its last beat has passed.

The block also holds the mode register fields for burst length, burst ordering and CAS latency. It classifies clock-enable-low periods as power-down, clock suspend or self-refresh. It produces the per-lane mask timing for the data buffers: read lanes are disabled two clocks after a high mask, and write lanes are blocked in the same cycle as the mask. Commands that do not fit the current bank state are rejected with a one-cycle illegal flag and change nothing.

Top module: `sdram_cmd_front`

## Requirements
- R1: With cs_n low and cke high at an edge, {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode load. Every other pattern is a no-operation. An accepted command raises exactly one strobe during the cycle after that edge, together with stb_bank = ba, stb_row = addr and stb_col = addr[7:0].
- R2: At an edge where cs_n is high, nothing is decoded. No strobe or illegal flag follows, and bank state and any running burst carry on unchanged.
- R3: An activate to a closed bank opens it and stores addr as its row. Bank b's row is bank_rows[12*b+11:12*b], and bank_open[b] is its flag.
- R4: A read or write to a closed bank, or an activate to an open bank, raises illegal_cmd for one cycle instead of a strobe and alters no state.
- R5: A precharge with addr[10]=1 closes every bank and sets pre_all. With addr[10]=0 it closes only bank ba.
- R6: A read or write with addr[10]=1 sets stb_auto_pre. The bank closes at the edge of its last burst beat: beats occur at the command edge and at each following edge with cke high. A full-page burst never auto-closes. A new read or write, or a precharge of the burst's bank, ends a running burst and drops its pending close.
- R7: Refresh and mode load are accepted only when all banks are closed. Otherwise they raise illegal_cmd.
- R8: A mode load takes addr[2:0] as the burst code (0..3 give 1, 2, 4 or 8 beats; 7 gives full page; other codes leave the old value), addr[3] as interleaved ordering, and addr[6:4] as CAS latency, which is only taken if it is 2 or 3. After reset the values are code 0, sequential ordering and latency 2.
- R9: rd_lane_oe[i] is the inverse of dqm[i] as sampled two edges earlier; it changes after the second edge. Lane 1 is the upper byte.
- R10: wr_byte_en is ~dqm, with no register, in any cycle that carries a write beat: an accepted write command, or a running write burst with cke high that is not being ended in that cycle. In all other cycles it is 0.
- R11: At an edge with cke low no command is executed and lp_state updates. A refresh pattern with all banks closed enters self-refresh (3). A running burst enters suspend (2) and freezes the burst. Otherwise the block enters power-down (1). A low-power state holds while cke stays low and returns to run (0) at the next edge with cke high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Multiplexed row/column address; bit 10 selects all-bank / auto-precharge |
| dqm | input | 2 | Byte masks, bit 1 upper lane |
| act_stb | output | 1 | Activate accepted |
| rd_stb | output | 1 | Read accepted |
| wr_stb | output | 1 | Write accepted |
| pre_stb | output | 1 | Precharge accepted |
| ref_stb | output | 1 | Auto-refresh accepted |
| mrs_stb | output | 1 | Mode load accepted |
| stb_bank | output | 2 | Bank of the strobed command |
| stb_row | output | 12 | Address of the strobed command |
| stb_col | output | 8 | Column of the strobed command |
| stb_auto_pre | output | 1 | Read/write carries auto-precharge |
| pre_all | output | 1 | Precharge closed all banks |
| illegal_cmd | output | 1 | Command rejected for bank state |
| bank_open | output | 4 | Per-bank open flag |
| bank_rows | output | 48 | Latched open row per bank |
| cfg_cl | output | 3 | CAS latency |
| cfg_bl | output | 3 | Burst length code |
| cfg_ilv | output | 1 | Interleaved burst ordering |
| lp_state | output | 2 | 0 run, 1 power-down, 2 suspend, 3 self-refresh |
| rd_lane_oe | output | 2 | Read output enable per lane |
| wr_byte_en | output | 2 | Write byte enable per lane |

## Verification
The hardest case to reach is an auto-precharge burst that is frozen by clock suspend partway through. The bank must stay open through the low-cke edges and close exactly at the edge of the last resumed beat. The stimulus opens a bank, issues a four-beat write with auto-precharge, holds cke low for two edges while offering an activate that must be ignored, and then counts the resumed beats. The bench checks the bank flag one edge before and at the expected close. Full-page bursts and mode loads with out-of-range latency are covered in the same way, with precharge used to end the bursts.

// File: rtl/sdram_fe_pkg.sv
package sdram_fe_pkg;

   typedef enum logic [2:0] {
      OP_NOP = 3'd0,
      OP_ACT = 3'd1,
      OP_RD  = 3'd2,
      OP_WR  = 3'd3,
      OP_PRE = 3'd4,
      OP_REF = 3'd5,
      OP_MRS = 3'd6
   } op_e;

   typedef enum logic [1:0] {
      LP_RUN  = 2'd0,
      LP_PDN  = 2'd1,
      LP_SUSP = 2'd2,
      LP_SREF = 2'd3
   } lp_e;

   // mode register field positions inside the address bus
   localparam int MODE_BL_LSB  = 0;
   localparam int MODE_ILV_BIT = 3;
   localparam int MODE_CL_LSB  = 4;
   localparam int MODE_FIELD_W = 3;

endpackage

// File: rtl/sdram_fe_decode.sv
module sdram_fe_decode
   import sdram_fe_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output op_e  op
);

   always_comb begin
      op = OP_NOP;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  op = OP_ACT;
            3'b101:  op = OP_RD;
            3'b100:  op = OP_WR;
            3'b010:  op = OP_PRE;
            3'b001:  op = OP_REF;
            3'b000:  op = OP_MRS;
            default: op = OP_NOP;
         endcase
      end
   end

endmodule

// File: rtl/sdram_fe_banks.sv
module sdram_fe_banks #(
   parameter  int NUM_BANKS = 4,
   parameter  int ROW_W     = 12,
   localparam int BANK_W    = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       act_en,
   input  logic [BANK_W-1:0]          act_bank,
   input  logic [ROW_W-1:0]           act_row,
   input  logic [NUM_BANKS-1:0]       close_mask,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] bank_rows
);

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic             open_q;
      logic [ROW_W-1:0] row_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            open_q <= 1'b0;
            row_q  <= '0;
         end else if (close_mask[g]) begin
            open_q <= 1'b0;
         end else if (act_en && (act_bank == BANK_W'(g))) begin
            open_q <= 1'b1;
            row_q  <= act_row;
         end
      end

      assign bank_open[g]                  = open_q;
      assign bank_rows[g*ROW_W +: ROW_W]   = row_q;
   end

endmodule

// File: rtl/sdram_fe_burst.sv
module sdram_fe_burst #(
   parameter  int NUM_BANKS = 4,
   parameter  int MAX_BURST = 8,
   parameter  int FULL_CODE = 7,
   localparam int BANK_W    = $clog2(NUM_BANKS),
   localparam int CNT_W     = $clog2(MAX_BURST)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 adv,
   input  logic                 load,
   input  logic                 load_wr,
   input  logic                 load_ap,
   input  logic [BANK_W-1:0]    load_bank,
   input  logic [2:0]           bl_code,
   input  logic                 pre_en,
   input  logic                 pre_every,
   input  logic [BANK_W-1:0]    pre_bank,
   output logic                 active,
   output logic                 burst_wr,
   output logic                 stop,
   output logic [NUM_BANKS-1:0] close_mask
);

   logic [CNT_W-1:0]  cnt_q;
   logic              fp_q;
   logic              ap_q;
   logic              wr_q;
   logic [BANK_W-1:0] bank_q;

   logic [CNT_W:0]    pow;
   logic [CNT_W:0]    pow_m1;
   logic [CNT_W-1:0]  len_m1;
   logic              full;
   logic              last_now;
   logic              last_run;

   always_comb begin
      pow    = (CNT_W+1)'(1) << bl_code;
      pow_m1 = pow - (CNT_W+1)'(1);
      len_m1 = pow_m1[CNT_W-1:0];
      full   = (bl_code == 3'(FULL_CODE));
   end

   assign active   = fp_q || (cnt_q != '0);
   assign burst_wr = wr_q;
   assign stop     = pre_en && !load && active && (pre_every || (pre_bank == bank_q));

   assign last_now = load && load_ap && !full && (len_m1 == '0);
   assign last_run = !load && !stop && adv && ap_q && (cnt_q == CNT_W'(1));

   always_comb begin
      close_mask = '0;
      if (last_now)      close_mask = NUM_BANKS'(1) << load_bank;
      else if (last_run) close_mask = NUM_BANKS'(1) << bank_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fp_q   <= 1'b0;
         ap_q   <= 1'b0;
         wr_q   <= 1'b0;
         bank_q <= '0;
      end else if (load) begin
         cnt_q  <= full ? '0 : len_m1;
         fp_q   <= full;
         ap_q   <= load_ap && !full && (len_m1 != '0);
         wr_q   <= load_wr;
         bank_q <= load_bank;
      end else if (stop) begin
         cnt_q <= '0;
         fp_q  <= 1'b0;
         ap_q  <= 1'b0;
      end else if (adv && (cnt_q != '0)) begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_q == CNT_W'(1)) ap_q <= 1'b0;
      end
   end

endmodule

// File: rtl/sdram_fe_dqm.sv
module sdram_fe_dqm #(
   parameter int LANES = 2,
   parameter int LAT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] dqm,
   output logic [LANES-1:0] rd_oe
);

   if (LAT == 0) begin : g_direct
      assign rd_oe = ~dqm;
   end else begin : g_pipe
      logic [LANES-1:0] stage_q [LAT];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < LAT; i++) stage_q[i] <= '0;
         end else begin
            stage_q[0] <= dqm;
            for (int i = 1; i < LAT; i++) stage_q[i] <= stage_q[i-1];
         end
      end

      assign rd_oe = ~stage_q[LAT-1];
   end

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
   import sdram_fe_pkg::*;
#(
   parameter  int NUM_BANKS   = 4,
   parameter  int ROW_W       = 12,
   parameter  int COL_W       = 8,
   parameter  int AP_BIT      = 10,
   parameter  int LANES       = 2,
   parameter  int RD_MASK_LAT = 2,
   parameter  int MAX_BURST   = 8,
   parameter  int FULL_CODE   = 7,
   parameter  int CL_MIN      = 2,
   parameter  int CL_MAX      = 3,
   localparam int BANK_W      = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cke,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BANK_W-1:0]          ba,
   input  logic [ROW_W-1:0]           addr,
   input  logic [LANES-1:0]           dqm,
   output logic                       act_stb,
   output logic                       rd_stb,
   output logic                       wr_stb,
   output logic                       pre_stb,
   output logic                       ref_stb,
   output logic                       mrs_stb,
   output logic [BANK_W-1:0]          stb_bank,
   output logic [ROW_W-1:0]           stb_row,
   output logic [COL_W-1:0]           stb_col,
   output logic                       stb_auto_pre,
   output logic                       pre_all,
   output logic                       illegal_cmd,
   output logic [NUM_BANKS-1:0]       bank_open,
   output logic [NUM_BANKS*ROW_W-1:0] bank_rows,
   output logic [2:0]                 cfg_cl,
   output logic [2:0]                 cfg_bl,
   output logic                       cfg_ilv,
   output logic [1:0]                 lp_state,
   output logic [LANES-1:0]           rd_lane_oe,
   output logic [LANES-1:0]           wr_byte_en
);

   localparam int BL_MAX_CODE = $clog2(MAX_BURST);

   // elaboration-time parameter checks
   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (AP_BIT >= ROW_W || AP_BIT < COL_W) begin : g_bad_ap
      $error("AP_BIT must lie above the column field and inside the row field");
   end
   if (ROW_W < MODE_CL_LSB + MODE_FIELD_W) begin : g_bad_row
      $error("ROW_W too narrow for the mode register fields");
   end
   if (MAX_BURST < 2 || (1 << BL_MAX_CODE) != MAX_BURST || BL_MAX_CODE >= FULL_CODE) begin : g_bad_burst
      $error("MAX_BURST must be a power of two below the full-page code");
   end
   if (CL_MIN > CL_MAX || CL_MAX > 7) begin : g_bad_cl
      $error("CAS latency range invalid");
   end

   // ---------------- decode ----------------
   op_e op;

   sdram_fe_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .op    (op)
   );

   logic tgt_open;
   logic all_closed;
   logic ap_flag;
   logic acc_act, acc_rd, acc_wr, acc_pre, acc_ref, acc_mrs, bad_cmd;

   always_comb begin
      tgt_open   = bank_open[ba];
      all_closed = (bank_open == '0);
      ap_flag    = addr[AP_BIT];
      acc_act    = cke && (op == OP_ACT) && !tgt_open;
      acc_rd     = cke && (op == OP_RD)  && tgt_open;
      acc_wr     = cke && (op == OP_WR)  && tgt_open;
      acc_pre    = cke && (op == OP_PRE);
      acc_ref    = cke && (op == OP_REF) && all_closed;
      acc_mrs    = cke && (op == OP_MRS) && all_closed;
      bad_cmd    = cke && (((op == OP_ACT) && tgt_open) ||
                           (((op == OP_RD) || (op == OP_WR)) && !tgt_open) ||
                           (((op == OP_REF) || (op == OP_MRS)) && !all_closed));
   end

   // ---------------- burst tracking ----------------
   logic                 brst_active;
   logic                 brst_wr;
   logic                 brst_stop;
   logic [NUM_BANKS-1:0] ap_close;

   sdram_fe_burst #(
      .NUM_BANKS (NUM_BANKS),
      .MAX_BURST (MAX_BURST),
      .FULL_CODE (FULL_CODE)
   ) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (cke),
      .load       (acc_rd || acc_wr),
      .load_wr    (acc_wr),
      .load_ap    (ap_flag),
      .load_bank  (ba),
      .bl_code    (cfg_bl),
      .pre_en     (acc_pre),
      .pre_every  (ap_flag),
      .pre_bank   (ba),
      .active     (brst_active),
      .burst_wr   (brst_wr),
      .stop       (brst_stop),
      .close_mask (ap_close)
   );

   // ---------------- bank table ----------------
   logic [NUM_BANKS-1:0] pre_close;

   always_comb begin
      pre_close = '0;
      if (acc_pre) pre_close = ap_flag ? '1 : (NUM_BANKS'(1) << ba);
   end

   sdram_fe_banks #(
      .NUM_BANKS (NUM_BANKS),
      .ROW_W     (ROW_W)
   ) u_banks (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_en     (acc_act),
      .act_bank   (ba),
      .act_row    (addr),
      .close_mask (pre_close | ap_close),
      .bank_open  (bank_open),
      .bank_rows  (bank_rows)
   );

   // ---------------- mode register ----------------
   logic [2:0] mode_bl_in;
   logic [2:0] mode_cl_in;
   logic       bl_ok;
   logic       cl_ok;

   always_comb begin
      mode_bl_in = addr[MODE_BL_LSB +: MODE_FIELD_W];
      mode_cl_in = addr[MODE_CL_LSB +: MODE_FIELD_W];
      bl_ok      = (mode_bl_in <= 3'(BL_MAX_CODE)) || (mode_bl_in == 3'(FULL_CODE));
      cl_ok      = (mode_cl_in >= 3'(CL_MIN)) && (mode_cl_in <= 3'(CL_MAX));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_bl  <= '0;
         cfg_ilv <= 1'b0;
         cfg_cl  <= 3'(CL_MIN);
      end else if (acc_mrs) begin
         cfg_ilv <= addr[MODE_ILV_BIT];
         if (bl_ok) cfg_bl <= mode_bl_in;
         if (cl_ok) cfg_cl <= mode_cl_in;
      end
   end

   // ---------------- low-power classification ----------------
   lp_e lp_q;
   lp_e lp_d;

   always_comb begin
      if (cke)                                 lp_d = LP_RUN;
      else if (lp_q != LP_RUN)                 lp_d = lp_q;
      else if ((op == OP_REF) && all_closed)   lp_d = LP_SREF;
      else if (brst_active)                    lp_d = LP_SUSP;
      else                                     lp_d = LP_PDN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lp_q <= LP_RUN;
      else        lp_q <= lp_d;
   end

   assign lp_state = lp_q;

   // ---------------- strobes ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_stb      <= 1'b0;
         rd_stb       <= 1'b0;
         wr_stb       <= 1'b0;
         pre_stb      <= 1'b0;
         ref_stb      <= 1'b0;
         mrs_stb      <= 1'b0;
         illegal_cmd  <= 1'b0;
         stb_bank     <= '0;
         stb_row      <= '0;
         stb_col      <= '0;
         stb_auto_pre <= 1'b0;
         pre_all      <= 1'b0;
      end else begin
         act_stb      <= acc_act;
         rd_stb       <= acc_rd;
         wr_stb       <= acc_wr;
         pre_stb      <= acc_pre;
         ref_stb      <= acc_ref;
         mrs_stb      <= acc_mrs;
         illegal_cmd  <= bad_cmd;
         stb_bank     <= ba;
         stb_row      <= addr;
         stb_col      <= addr[COL_W-1:0];
         stb_auto_pre <= (acc_rd || acc_wr) && ap_flag;
         pre_all      <= acc_pre && ap_flag;
      end
   end

   // ---------------- byte masks ----------------
   sdram_fe_dqm #(
      .LANES (LANES),
      .LAT   (RD_MASK_LAT)
   ) u_dqm (
      .clk   (clk),
      .rst_n (rst_n),
      .dqm   (dqm),
      .rd_oe (rd_lane_oe)
   );

   logic wr_beat;

   always_comb begin
      wr_beat    = acc_wr || (brst_active && brst_wr && cke && !acc_rd && !brst_stop);
      wr_byte_en = wr_beat ? ~dqm : '0;
   end

endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk #(
   parameter  int NUM_BANKS = 4,
   localparam int BANK_W    = $clog2(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cs_n,
   input logic                 act_stb,
   input logic                 rd_stb,
   input logic                 wr_stb,
   input logic                 pre_stb,
   input logic                 ref_stb,
   input logic                 mrs_stb,
   input logic [BANK_W-1:0]    stb_bank,
   input logic                 pre_all,
   input logic                 illegal_cmd,
   input logic [NUM_BANKS-1:0] bank_open,
   input logic [1:0]           lp_state
);

   logic [5:0] stbs;
   assign stbs = {act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb};

   assert_one_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(stbs));

   assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cs_n) |-> (stbs == '0) && !illegal_cmd);

   assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      act_stb |-> bank_open[stb_bank]);

   assert_illegal_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_cmd |-> (stbs == '0));

   assert_access_needs_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb || wr_stb) |-> ($past(bank_open) != '0));

   assert_pre_all_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_stb && pre_all) |-> (bank_open == '0));

   assert_sref_closed_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (lp_state == 2'd3) |-> (bank_open == '0));

endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cs_n        (cs_n),
   .act_stb     (act_stb),
   .rd_stb      (rd_stb),
   .wr_stb      (wr_stb),
   .pre_stb     (pre_stb),
   .ref_stb     (ref_stb),
   .mrs_stb     (mrs_stb),
   .stb_bank    (stb_bank),
   .pre_all     (pre_all),
   .illegal_cmd (illegal_cmd),
   .bank_open   (bank_open),
   .lp_state    (lp_state)
);

// File: tb/sdram_cmd_front_test.sv
module sdram_cmd_front_test;

   localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                          P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000,
                          P_NOP = 3'b111;
   localparam logic [2:0] E_NONE = 3'd0, E_ACT = 3'd1, E_RD = 3'd2, E_WR = 3'd3,
                          E_PRE = 3'd4, E_REF = 3'd5, E_MRS = 3'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic [1:0]  dqm = '0;

   logic        act_stb, rd_stb, wr_stb, pre_stb, ref_stb, mrs_stb;
   logic [1:0]  stb_bank;
   logic [11:0] stb_row;
   logic [7:0]  stb_col;
   logic        stb_auto_pre, pre_all, illegal_cmd;
   logic [3:0]  bank_open;
   logic [47:0] bank_rows;
   logic [2:0]  cfg_cl, cfg_bl;
   logic        cfg_ilv;
   logic [1:0]  lp_state, rd_lane_oe, wr_byte_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct packed {
      logic [2:0] code;
      logic [1:0] bank;
      logic       ill;
   } exp_t;

   exp_t exp_q[$];

   always #5 clk = ~clk;

   sdram_cmd_front uut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .dqm(dqm),
      .act_stb(act_stb), .rd_stb(rd_stb), .wr_stb(wr_stb), .pre_stb(pre_stb),
      .ref_stb(ref_stb), .mrs_stb(mrs_stb), .stb_bank(stb_bank),
      .stb_row(stb_row), .stb_col(stb_col), .stb_auto_pre(stb_auto_pre),
      .pre_all(pre_all), .illegal_cmd(illegal_cmd), .bank_open(bank_open),
      .bank_rows(bank_rows), .cfg_cl(cfg_cl), .cfg_bl(cfg_bl), .cfg_ilv(cfg_ilv),
      .lp_state(lp_state), .rd_lane_oe(rd_lane_oe), .wr_byte_en(wr_byte_en)
   );

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, got, exp);
      end
   endtask

   function automatic logic [2:0] dut_code();
      if (act_stb) return E_ACT;
      if (rd_stb)  return E_RD;
      if (wr_stb)  return E_WR;
      if (pre_stb) return E_PRE;
      if (ref_stb) return E_REF;
      if (mrs_stb) return E_MRS;
      return E_NONE;
   endfunction

   // driver: sets pins and pushes the expected strobe for the coming edge
   task automatic drive(input logic [2:0] rcw, input logic ck, input logic csn,
                        input logic [1:0] b, input logic [11:0] a, input logic [1:0] m,
                        input logic [2:0] ecode, input logic eill);
      exp_t e;
      {ras_n, cas_n, we_n} = rcw;
      cke  = ck;
      cs_n = csn;
      ba   = b;
      addr = a;
      dqm  = m;
      e.code = ecode;
      e.bank = b;
      e.ill  = eill;
      exp_q.push_back(e);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic step(input logic [2:0] rcw, input logic ck, input logic [1:0] b,
                       input logic [11:0] a, input logic [2:0] ecode, input logic eill);
      drive(rcw, ck, 1'b0, b, a, 2'b00, ecode, eill);
      tick();
   endtask

   // monitor: pops one expected item per edge and compares the strobes
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk("R1 strobe code", 64'(dut_code()), 64'(e.code));
            chk("R4 illegal flag", 64'(illegal_cmd), 64'(e.ill));
            if (e.code != E_NONE) chk("R1 strobe bank", 64'(stb_bank), 64'(e.bank));
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R8, R11)
      chk("R8 reset cl", 64'(cfg_cl), 64'd2);
      chk("R8 reset bl", 64'(cfg_bl), 64'd0);
      chk("R11 reset lp", 64'(lp_state), 64'd0);
      chk("R3 reset banks", 64'(bank_open), 64'd0);
      chk("R1 reset strobes", 64'(dut_code()), 64'(E_NONE));

      // mode load: CL3, BL4
      step(P_MRS, 1'b1, 2'd0, 12'h032, E_MRS, 1'b0);
      chk("R8 cl set", 64'(cfg_cl), 64'd3);
      chk("R8 bl set", 64'(cfg_bl), 64'd2);
      // CL5 invalid, kept at 3
      step(P_MRS, 1'b1, 2'd0, 12'h052, E_MRS, 1'b0);
      chk("R8 cl out of range kept", 64'(cfg_cl), 64'd3);

      // activate bank 1
      step(P_ACT, 1'b1, 2'd1, 12'hABC, E_ACT, 1'b0);
      chk("R3 bank1 open", 64'(bank_open), 64'h2);
      chk("R3 bank1 row", 64'(bank_rows[23:12]), 64'hABC);
      chk("R1 stb_row", 64'(stb_row), 64'hABC);
      // illegal cases
      step(P_ACT, 1'b1, 2'd1, 12'h111, E_NONE, 1'b1);
      chk("R4 row unchanged", 64'(bank_rows[23:12]), 64'hABC);
      step(P_RD, 1'b1, 2'd2, 12'h000, E_NONE, 1'b1);
      step(P_REF, 1'b1, 2'd0, 12'h000, E_NONE, 1'b1);
      step(P_MRS, 1'b1, 2'd0, 12'h020, E_NONE, 1'b1);
      chk("R7 mode unchanged", 64'(cfg_cl), 64'd3);
      // deselected activate
      drive(P_ACT, 1'b1, 1'b1, 2'd0, 12'h555, 2'b00, E_NONE, 1'b0);
      tick();
      chk("R2 deselect no open", 64'(bank_open), 64'h2);

      // precharge single then all
      step(P_ACT, 1'b1, 2'd2, 12'h123, E_ACT, 1'b0);
      step(P_PRE, 1'b1, 2'd1, 12'h000, E_PRE, 1'b0);
      chk("R5 single close", 64'(bank_open), 64'h4);
      chk("R5 pre_all low", 64'(pre_all), 64'd0);
      step(P_PRE, 1'b1, 2'd0, 12'h400, E_PRE, 1'b0);
      chk("R5 all closed", 64'(bank_open), 64'h0);
      chk("R5 pre_all high", 64'(pre_all), 64'd1);

      // write BL4 with auto-precharge on bank 3
      step(P_ACT, 1'b1, 2'd3, 12'h005, E_ACT, 1'b0);
      drive(P_WR, 1'b1, 1'b0, 2'd3, 12'h410, 2'b01, E_WR, 1'b0);
      #1 chk("R10 same-cycle mask", 64'(wr_byte_en), 64'h2);
      tick();
      chk("R6 auto-pre tag", 64'(stb_auto_pre), 64'd1);
      chk("R1 stb_col", 64'(stb_col), 64'h10);
      drive(P_NOP, 1'b1, 1'b0, 2'd0, 12'h000, 2'b00, E_NONE, 1'b0);
      #1 chk("R10 burst beat", 64'(wr_byte_en), 64'h3);
      tick();
      drive(P_NOP, 1'b1, 1'b0, 2'd0, 12'h000, 2'b10, E_NONE, 1'b0);
      #1 chk("R10 upper masked", 64'(wr_byte_en), 64'h1);
      tick();
      chk("R6 still open", 64'(bank_open), 64'h8);
      step(P_NOP, 1'b1, 2'd0, 12'h000, E_NONE, 1'b0);
      chk("R6 closed at last beat", 64'(bank_open), 64'h0);
      drive(P_NOP, 1'b1, 1'b0, 2'd0, 12'h000, 2'b00, E_NONE, 1'b0);
      #1 chk("R10 no beat after burst", 64'(wr_byte_en), 64'h0);
      tick();

      // suspend during auto-precharge write on bank 0
      step(P_ACT, 1'b1, 2'd0, 12'h777, E_ACT, 1'b0);
      step(P_WR, 1'b1, 2'd0, 12'h400, E_WR, 1'b0);
      drive(P_NOP, 1'b0, 1'b0, 2'd0, 12'h000, 2'b00, E_NONE, 1'b0);
      #1 chk("R10 no beat while suspended", 64'(wr_byte_en), 64'h0);
      tick();
      chk("R11 suspend", 64'(lp_state), 64'd2);
      step(P_ACT, 1'b0, 2'd1, 12'h333, E_NONE, 1'b0);
      chk("R11 cmd ignored", 64'(bank_open), 64'h1);
      chk("R11 suspend held", 64'(lp_state), 64'd2);
      drive(P_NOP, 1'b1, 1'b0, 2'd0, 12'h000, 2'b00, E_NONE, 1'b0);
      #1 chk("R10 resumed beat", 64'(wr_byte_en), 64'h3);
      tick();
      chk("R11 back to run", 64'(lp_state), 64'd0);
      step(P_NOP, 1'b1, 2'd0, 12'h000, E_NONE, 1'b0);
      chk("R6 open before last", 64'(bank_open), 64'h1);
      step(P_NOP, 1'b1, 2'd0, 12'h000, E_NONE, 1'b0);
      chk("R6 closed after resume", 64'(bank_open), 64'h0);

      // power-down and self-refresh
      step(P_NOP, 1'b0, 2'd0, 12'h000, E_NONE, 1'b0);
      chk("R11 power-down", 64'(lp_state), 64'd1);
      step(P_NOP, 1'b1, 2'd0, 12'h000, E_NONE, 1'b0);
      step(P_REF, 1'b0, 2'd0, 12'h000, E_NONE, 1'b0);
      chk("R11 self-refresh", 64'(lp_state), 64'd3);
      step(P_NOP, 1'b0, 2'd0, 12'h000, E_NONE, 1'b0);
      chk("R11 self-refresh held", 64'(lp_state), 64'd3);
      step(P_NOP, 1'b1, 2'd0, 12'h000, E_NONE, 1'b0);
      chk("R11 exit", 64'(lp_state), 64'd0);
      step(P_REF, 1'b1, 2'd0, 12'h000, E_REF, 1'b0);

      // read lane mask two edges later
      drive(P_NOP, 1'b1, 1'b0, 2'd0, 12'h000, 2'b10, E_NONE, 1'b0);
      tick();
      chk("R9 not yet", 64'(rd_lane_oe), 64'h3);
      step(P_NOP, 1'b1, 2'd0, 12'h000, E_NONE, 1'b0);
      chk("R9 upper off", 64'(rd_lane_oe), 64'h1);
      step(P_NOP, 1'b1, 2'd0, 12'h000, E_NONE, 1'b0);
      chk("R9 restored", 64'(rd_lane_oe), 64'h3);

      // full page burst ignores auto-precharge
      step(P_MRS, 1'b1, 2'd0, 12'h037, E_MRS, 1'b0);
      chk("R8 full page code", 64'(cfg_bl), 64'd7);
      step(P_ACT, 1'b1, 2'd2, 12'h0F0, E_ACT, 1'b0);
      step(P_WR, 1'b1, 2'd2, 12'h4AA, E_WR, 1'b0);
      for (int i = 0; i < 9; i++) step(P_NOP, 1'b1, 2'd0, 12'h000, E_NONE, 1'b0);
      drive(P_NOP, 1'b1, 1'b0, 2'd0, 12'h000, 2'b00, E_NONE, 1'b0);
      #1 chk("R10 full page beat", 64'(wr_byte_en), 64'h3);
      tick();
      chk("R6 full page stays open", 64'(bank_open), 64'h4);
      step(P_PRE, 1'b1, 2'd2, 12'h000, E_PRE, 1'b0);
      chk("R5 burst bank closed", 64'(bank_open), 64'h0);
      drive(P_NOP, 1'b1, 1'b0, 2'd0, 12'h000, 2'b00, E_NONE, 1'b0);
      #1 chk("R6 burst ended by precharge", 64'(wr_byte_en), 64'h0);
      tick();

      // interleave and a plain read
      step(P_MRS, 1'b1, 2'd0, 12'h03A, E_MRS, 1'b0);
      chk("R8 interleave", 64'(cfg_ilv), 64'd1);
      chk("R8 bl back to 4", 64'(cfg_bl), 64'd2);
      step(P_ACT, 1'b1, 2'd0, 12'h001, E_ACT, 1'b0);
      step(P_RD, 1'b1, 2'd0, 12'h055, E_RD, 1'b0);
      chk("R1 read column", 64'(stb_col), 64'h55);
      chk("R6 no auto-pre tag", 64'(stb_auto_pre), 64'd0);
      step(P_PRE, 1'b1, 2'd0, 12'h400, E_PRE, 1'b0);
      chk("R5 read bank closed", 64'(bank_open), 64'h0);

      @(posedge clk);
      #3;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule